// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block computes a cyclic redundancy checksum over a stream of data writes. One of three fixed generator polynomials is chosen at a time: two 16-bit ones and one 32-bit one. Software or a mover loads a seed, then writes the data as bytes, half-words or words. The running remainder is kept inside the block. The checksum port shows that remainder after the optional read-out transforms.

The engine folds one byte into the remainder per clock. A byte write is finished at the clock edge that accepts it. Longer writes keep the engine busy for the remaining bytes, and a ready signal holds off the next write until they are done. The data path can apply bit reversal, byte reversal and inversion to each write. The read-out path has its own, separate set of the same three options. A seed write restarts the computation at once.

Top module: `crc_engine`

## Requirements
- R1: After reset the checksum reads 0, busy is low and wr_ready is high.
- R2: The cfg_poly code selects the polynomial. Code 0 selects 0x8005 (16-bit), code 1 selects 0x1021 (16-bit), and codes 2 and 3 select 0x04C11DB7 (32-bit). The remainder is shifted most-significant bit first with no implicit reflection. In 16-bit modes checksum bits 31:16 read 0 and only bits 15:0 of the seed are used.
- R3: A seed_wr pulse loads the remainder at that clock edge and cancels any bytes still pending, so busy is low afterwards. While seed_wr is high, wr_ready is low.
- R4: The wr_size code gives the write size: 0 is a byte (bits 7:0), 1 is a half-word (bits 15:0), and 2 or 3 is a word. Bits above the written size have no effect.
- R5: The bytes of a write are folded least-significant byte first. Any data byte reversal is applied before this ordering.
- R6: A byte write never raises busy. A half-word write holds busy high for 1 cycle after acceptance and a word write for 3 cycles. wr_ready equals not busy and not seed_wr.
- R7: When cfg_din_bitrev is set, the bit order inside each written byte is reversed.
- R8: When cfg_din_byterev is set, the byte order within the written size is reversed.
- R9: When cfg_din_invert is set, every bit within the written size is inverted.
- R10: When cfg_sum_bitrev is set, the checksum shows the remainder with all 16 or 32 bits in reversed order.
- R11: When cfg_sum_byterev is set, the checksum shows the remainder with its 2 or 4 bytes in reversed order.
- R12: When cfg_sum_invert is set, the checksum shows the inverted remainder, inverted over 16 or 32 bits.
- R13: The read-out options never change the internal remainder. Changing them mid-stream does not alter the results of later writes.
- R14: A write offered while busy is held (wr_ready low) and is accepted once the previous bytes are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_poly | input | 2 | Polynomial select code |
| cfg_din_bitrev | input | 1 | Reverse bits inside each data byte |
| cfg_din_byterev | input | 1 | Reverse data byte order within the write size |
| cfg_din_invert | input | 1 | Invert data within the write size |
| cfg_sum_bitrev | input | 1 | Reverse all checksum bits on read-out |
| cfg_sum_byterev | input | 1 | Reverse checksum byte order on read-out |
| cfg_sum_invert | input | 1 | Invert checksum on read-out |
| seed_wr | input | 1 | Seed load strobe |
| seed_val | input | 32 | Seed value |
| wr_valid | input | 1 | Data write request |
| wr_ready | output | 1 | Engine can accept a write |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data |
| busy | output | 1 | Bytes of an accepted write remain |
| checksum | output | 32 | Formatted remainder |

## Verification
The well-known nine-character test string "123456789" is fed under four parameter sets. Each ends in a published check value: zero-seeded 0x1021, all-ones-seeded 0x1021, 0x8005 with both reflections, and reflected and inverted 32-bit. These fix the polynomial constants, the bit order of the update and the read-out transforms. The same string sent as words, half-words and single bytes tells apart the byte-fold order and the size decoding. Word and half-word streams with data byte reversal, inversion and junk in unused upper bits are checked write by write against a bit-serial reference model, which separates the in-size transforms from the out-of-size bits. Dedicated sequences change the read-out options mid-stream, cancel a pending word with a seed, and stall a write behind a busy word.

// File: rtl/crc_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the CRC engine.
// Assumes a byte is 8 bits and data writes are at most one word.
package crc_pkg;

    // One set of transform options: used for the data path and for the read-out path
    typedef struct packed {
        logic bitrev;
        logic byterev;
        logic invert;
    } xform_t;

    // Number of bytes minus one that a size code carries, limited by the data width
    function automatic int unsigned size_to_last(input logic [1:0] code, input int unsigned bytes);
        int unsigned n;
        case (code)
            2'd0:    n = 1;
            2'd1:    n = 2;
            default: n = bytes;
        endcase
        if (n > bytes) n = bytes;
        return n - 1;
    endfunction

endpackage

// File: rtl/crc_data_prep.sv
`timescale 1ns/1ps
// Input conditioning: applies the data transforms within the written size
// and zeroes the bytes above it. Purely combinational.
// Assumes DATA_W is a whole number of bytes.
module crc_data_prep
    import crc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        size,
    input  xform_t            opt,
    output logic [DATA_W-1:0] prepped,
    output logic [CNT_W-1:0]  last_idx
);

    logic [DATA_W-1:0] flipped;
    logic [DATA_W-1:0] ordered;
    int unsigned       last;

    // Bit reversal inside each byte lane
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        for (genvar b = 0; b < 8; b++) begin : g_bit
            assign flipped[g*8 + b] = opt.bitrev ? raw[g*8 + 7 - b] : raw[g*8 + b];
        end
    end

    // Size decode
    always_comb last = size_to_last(size, BYTES);
    assign last_idx = CNT_W'(last);

    // Byte reordering within the size, then inversion and masking of unused lanes
    always_comb begin
        ordered = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (k <= int'(last)) begin
                if (opt.byterev)
                    ordered[k*8 +: 8] = flipped[(int'(last) - k)*8 +: 8];
                else
                    ordered[k*8 +: 8] = flipped[k*8 +: 8];
                if (opt.invert)
                    ordered[k*8 +: 8] = ~ordered[k*8 +: 8];
            end
        end
        prepped = ordered;
    end

endmodule

// File: rtl/crc_byte_step.sv
`timescale 1ns/1ps
// Folds one byte into the remainder, most-significant bit first.
// The narrow polynomial works in the upper half of a left-aligned register,
// so the wide and narrow cases share one chain of eight shift stages.
// Assumes poly_al holds the polynomial left-aligned to CRC_W bits.
module crc_byte_step #(
    parameter int CRC_W = 32,
    parameter int NARROW_W = 16
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    input  logic             wide,
    input  logic [CRC_W-1:0] poly_al,
    output logic [CRC_W-1:0] crc_out
);

    localparam int PAD = CRC_W - NARROW_W;

    logic [CRC_W-1:0] stage [0:8];

    // Left-align the remainder and inject the byte at the top
    always_comb begin
        if (wide) stage[0] = crc_in ^ {byte_in, {(CRC_W-8){1'b0}}};
        else      stage[0] = {crc_in[NARROW_W-1:0], {PAD{1'b0}}} ^ {byte_in, {(CRC_W-8){1'b0}}};
    end

    // Eight conditional shift-and-subtract stages
    for (genvar s = 0; s < 8; s++) begin : g_stage
        assign stage[s+1] = stage[s][CRC_W-1] ? ((stage[s] << 1) ^ poly_al) : (stage[s] << 1);
    end

    // Realign the narrow result to the low bits
    always_comb begin
        if (wide) crc_out = stage[8];
        else      crc_out = {{PAD{1'b0}}, stage[8][CRC_W-1 -: NARROW_W]};
    end

endmodule

// File: rtl/crc_out_fmt.sv
`timescale 1ns/1ps
// Read-out formatting of the remainder: full-width bit reversal, byte
// reversal and inversion over 16 or 32 bits. Never feeds back into state.
module crc_out_fmt
    import crc_pkg::*;
#(
    parameter int CRC_W = 32,
    parameter int NARROW_W = 16
) (
    input  logic [CRC_W-1:0] rem,
    input  logic             wide,
    input  xform_t           opt,
    output logic [CRC_W-1:0] sum
);

    localparam int WB = CRC_W / 8;
    localparam int NB = NARROW_W / 8;

    logic [CRC_W-1:0]    rev_w, swap_w, pick_w;
    logic [NARROW_W-1:0] rev_n, swap_n, pick_n;

    // Full bit reversal for both widths
    for (genvar i = 0; i < CRC_W; i++) begin : g_rw
        assign rev_w[i] = rem[CRC_W-1-i];
    end
    for (genvar i = 0; i < NARROW_W; i++) begin : g_rn
        assign rev_n[i] = rem[NARROW_W-1-i];
    end

    // Byte reversal for both widths, applied after optional bit reversal
    for (genvar k = 0; k < WB; k++) begin : g_sw
        assign swap_w[k*8 +: 8] = opt.bitrev ? rev_w[(WB-1-k)*8 +: 8] : rem[(WB-1-k)*8 +: 8];
    end
    for (genvar k = 0; k < NB; k++) begin : g_sn
        assign swap_n[k*8 +: 8] = opt.bitrev ? rev_n[(NB-1-k)*8 +: 8] : rem[(NB-1-k)*8 +: 8];
    end

    // Select and invert per width
    always_comb begin
        pick_w = opt.byterev ? swap_w : (opt.bitrev ? rev_w : rem);
        pick_n = opt.byterev ? swap_n : (opt.bitrev ? rev_n : rem[NARROW_W-1:0]);
        if (opt.invert) begin
            pick_w = ~pick_w;
            pick_n = ~pick_n;
        end
        sum = wide ? pick_w : {{(CRC_W-NARROW_W){1'b0}}, pick_n};
    end

    // R2
    always_comb narrow_top_zero_chk: assert (wide || sum[CRC_W-1:NARROW_W] == '0);

endmodule

// File: rtl/crc_engine.sv
`timescale 1ns/1ps
// Multi-polynomial CRC engine: byte-per-clock sequencer around the data
// conditioning, one-byte update and read-out formatting blocks.
// Assumes cfg_poly is held steady while a write is in flight.
module crc_engine
    import crc_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [15:0] POLY16_A = 16'h8005,
    parameter logic [15:0] POLY16_B = 16'h1021,
    parameter logic [31:0] POLY32   = 32'h04C11DB7,
    localparam int CRC_W = 32,
    localparam int NARROW_W = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int PEND_W = (DATA_W > 8) ? DATA_W - 8 : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_poly,
    input  logic              cfg_din_bitrev,
    input  logic              cfg_din_byterev,
    input  logic              cfg_din_invert,
    input  logic              cfg_sum_bitrev,
    input  logic              cfg_sum_byterev,
    input  logic              cfg_sum_invert,
    input  logic              seed_wr,
    input  logic [CRC_W-1:0]  seed_val,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic [CRC_W-1:0]  checksum
);

    xform_t            din_opt, sum_opt;
    logic              wide, accept;
    logic [CRC_W-1:0]  poly_al;
    logic [DATA_W-1:0] prepped;
    logic [CNT_W-1:0]  last_idx;
    logic [7:0]        step_byte;
    logic [CRC_W-1:0]  step_out;
    logic [CRC_W-1:0]  rem_q;
    logic [PEND_W-1:0] pend_q;
    logic [CNT_W-1:0]  cnt_q;

    // Option bundling and polynomial alignment
    always_comb begin
        din_opt = '{bitrev: cfg_din_bitrev, byterev: cfg_din_byterev, invert: cfg_din_invert};
        sum_opt = '{bitrev: cfg_sum_bitrev, byterev: cfg_sum_byterev, invert: cfg_sum_invert};
        wide    = cfg_poly[1];
        case (cfg_poly)
            2'd0:    poly_al = {POLY16_A, 16'h0000};
            2'd1:    poly_al = {POLY16_B, 16'h0000};
            default: poly_al = POLY32;
        endcase
    end

    // Handshake: writes only when idle and no seed load competes
    assign busy     = (cnt_q != '0);
    assign wr_ready = !busy && !seed_wr;
    assign accept   = wr_valid && wr_ready;

    crc_data_prep #(.DATA_W(DATA_W)) u_prep (
        .raw      (wr_data),
        .size     (wr_size),
        .opt      (din_opt),
        .prepped  (prepped),
        .last_idx (last_idx)
    );

    // Byte source: pending bytes while busy, else lowest byte of the new write
    assign step_byte = busy ? pend_q[7:0] : prepped[7:0];

    crc_byte_step #(.CRC_W(CRC_W), .NARROW_W(NARROW_W)) u_step (
        .crc_in  (rem_q),
        .byte_in (step_byte),
        .wide    (wide),
        .poly_al (poly_al),
        .crc_out (step_out)
    );

    // Remainder and pending-byte sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
        end else if (seed_wr) begin
            rem_q  <= wide ? seed_val : {16'h0000, seed_val[NARROW_W-1:0]};
            pend_q <= '0;
            cnt_q  <= '0;
        end else if (busy) begin
            rem_q  <= step_out;
            pend_q <= pend_q >> 8;
            cnt_q  <= cnt_q - 1'b1;
        end else if (accept) begin
            rem_q  <= step_out;
            pend_q <= PEND_W'(prepped >> 8);
            cnt_q  <= last_idx;
        end
    end

    crc_out_fmt #(.CRC_W(CRC_W), .NARROW_W(NARROW_W)) u_fmt (
        .rem  (rem_q),
        .wide (wide),
        .opt  (sum_opt),
        .sum  (checksum)
    );

    // R3
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_wr |=> !busy && rem_q == (cfg_poly[1] ? $past(seed_val) : {16'h0000, $past(seed_val[15:0])}));

    // R6
    byte_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_size == 2'd0) |=> !busy);

    // R6
    multi_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_size != 2'd0) |=> busy);

    // R6
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seed_wr) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R13
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !accept && !seed_wr) |=> $stable(rem_q));

endmodule

// File: tb/crc_engine_tb.sv
`timescale 1ns/1ps
module crc_engine_tb;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } item_t;

    logic        clk = 0, rst_n = 0;
    logic [1:0]  cfg_poly = 0;
    logic        din_br = 0, din_yr = 0, din_iv = 0;
    logic        sum_br = 0, sum_yr = 0, sum_iv = 0;
    logic        seed_wr = 0;
    logic [31:0] seed_val = 0;
    logic        wr_valid = 0;
    logic        wr_ready;
    logic [1:0]  wr_size = 0;
    logic [31:0] wr_data = 0;
    logic        busy;
    logic [31:0] checksum;

    int checks = 0, fails = 0, last_stall = 0;
    bit done = 0;
    logic [31:0] mrem = 0;
    item_t q[$];

    crc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly),
        .cfg_din_bitrev(din_br), .cfg_din_byterev(din_yr), .cfg_din_invert(din_iv),
        .cfg_sum_bitrev(sum_br), .cfg_sum_byterev(sum_yr), .cfg_sum_invert(sum_iv),
        .seed_wr(seed_wr), .seed_val(seed_val), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_size(wr_size), .wr_data(wr_data), .busy(busy), .checksum(checksum)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: bit-serial feed of one byte
    function automatic logic [31:0] m_byte(logic [31:0] c, logic [7:0] b);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            if (cfg_poly[1]) begin
                fb = c[31] ^ b[i];
                c = c << 1;
                if (fb) c = c ^ 32'h04C11DB7;
            end else begin
                fb = c[15] ^ b[i];
                c = {16'h0, c[14:0], 1'b0};
                if (fb) c[15:0] = c[15:0] ^ (cfg_poly[0] ? 16'h1021 : 16'h8005);
            end
        end
        return c;
    endfunction

    // Reference: apply data options and feed all bytes of a write
    function automatic void m_feed(logic [31:0] d, logic [1:0] sz);
        int n;
        logic [7:0] b [4];
        logic [7:0] t;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < 4; k++) b[k] = d[k*8 +: 8];
        if (din_yr)
            for (int k = 0; k < n/2; k++) begin t = b[k]; b[k] = b[n-1-k]; b[n-1-k] = t; end
        for (int k = 0; k < n; k++) begin
            if (din_br) begin
                t = 0;
                for (int j = 0; j < 8; j++) t[j] = b[k][7-j];
                b[k] = t;
            end
            if (din_iv) b[k] = ~b[k];
            mrem = m_byte(mrem, b[k]);
        end
    endfunction

    // Reference: read-out view of the model remainder
    function automatic logic [31:0] m_out();
        int w;
        logic [31:0] v, r;
        w = cfg_poly[1] ? 32 : 16;
        v = mrem;
        if (sum_br) begin
            r = 0;
            for (int i = 0; i < w; i++) r[i] = v[w-1-i];
            v = r;
        end
        if (sum_yr) begin
            r = 0;
            for (int k = 0; k < w/8; k++) r[k*8 +: 8] = v[(w/8-1-k)*8 +: 8];
            v = r;
        end
        if (sum_iv) v = ~v;
        if (w == 16) v[31:16] = 0;
        return v;
    endfunction

    // Driver: offer a write, wait for ready, update model, push expectation
    task automatic do_write(logic [31:0] d, logic [1:0] sz, string tag);
        item_t it;
        @(negedge clk);
        wr_data = d; wr_size = sz; wr_valid = 1;
        last_stall = 0;
        while (!wr_ready) begin last_stall++; @(negedge clk); end
        @(posedge clk);
        m_feed(d, sz);
        it.val = m_out(); it.tag = tag;
        q.push_back(it);
        #1 wr_valid = 0;
    endtask

    task automatic drain();
        while (q.size() != 0 || busy) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(logic [1:0] p, logic dbr, logic dyr, logic div, logic sbr, logic syr, logic siv);
        drain();
        cfg_poly = p; din_br = dbr; din_yr = dyr; din_iv = div;
        sum_br = sbr; sum_yr = syr; sum_iv = siv;
    endtask

    task automatic load_seed(logic [31:0] s);
        drain();
        seed_val = s; seed_wr = 1;
        @(posedge clk);
        #1 seed_wr = 0;
        mrem = cfg_poly[1] ? s : {16'h0, s[15:0]};
    endtask

    // Monitor: compare each expectation once the engine is idle
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0 && !busy) begin
                it = q.pop_front();
                chk(it.tag, checksum, it.val);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic send_string_bytes(string tag);
        for (int i = 0; i < 9; i++) do_write(32'h31 + i, 2'd0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 checksum", checksum, 0);
        chk("R1 busy", {31'h0, busy}, 0);
        chk("R1 wr_ready", {31'h0, wr_ready}, 1);

        // R2 zero-seeded 0x1021, byte writes
        set_cfg(2'd1, 0, 0, 0, 0, 0, 0);
        load_seed(32'h0);
        send_string_bytes("R2 poly1 bytes");
        drain(); chk("R2 kat 1021 zero seed", checksum, 32'h31C3);

        // R2 all-ones seed, upper seed bits unused in 16-bit mode
        load_seed(32'hABCD_FFFF);
        send_string_bytes("R2 poly1 seeded");
        drain(); chk("R2 kat 1021 ffff seed", checksum, 32'h29B1);

        // R2 R4 R5 R7 R10 R12: 32-bit reflected/inverted, word and byte writes
        set_cfg(2'd2, 1, 0, 0, 1, 0, 1);
        load_seed(32'hFFFF_FFFF);
        do_write(32'h34333231, 2'd2, "R5 word lsb first");
        do_write(32'h38373635, 2'd2, "R5 word lsb first");
        do_write(32'hEEEEEE39, 2'd0, "R4 byte upper ignored");
        drain(); chk("R10 R12 kat crc32", checksum, 32'hCBF43926);

        // R2 R7 R10: 0x8005 reflected, half-word writes
        set_cfg(2'd0, 1, 0, 0, 1, 0, 0);
        load_seed(32'h0);
        do_write(32'h55553231, 2'd1, "R4 half upper ignored");
        do_write(32'h00003433, 2'd1, "R7 half");
        do_write(32'h00003635, 2'd1, "R7 half");
        do_write(32'h00003837, 2'd1, "R7 half");
        do_write(32'h00000039, 2'd0, "R7 byte");
        drain(); chk("R2 kat 8005 reflected", checksum, 32'hBB3D);
        chk("R2 narrow upper zero", {16'h0, checksum[31:16]}, 0);

        // R8 R9 R11: data byte reversal and inversion, read-out byte reversal
        set_cfg(2'd2, 0, 1, 0, 0, 1, 0);
        load_seed(32'h1234_5678);
        do_write(32'hDEADBEEF, 2'd2, "R8 word byterev");
        do_write(32'hFACE0102, 2'd1, "R8 half byterev");
        set_cfg(2'd3, 0, 0, 1, 0, 1, 0);
        do_write(32'h0BADF00D, 2'd2, "R9 word invert");
        do_write(32'h77770A0B, 2'd1, "R9 half invert");
        set_cfg(2'd1, 0, 1, 1, 0, 1, 1);
        load_seed(32'h0000_1D0F);
        do_write(32'hCAFE1357, 2'd2, "R11 narrow byterev");
        do_write(32'h000000A5, 2'd0, "R12 narrow invert");

        // R13: read-out options toggled mid-stream do not disturb state
        set_cfg(2'd2, 0, 0, 0, 1, 1, 1);
        load_seed(32'h0);
        do_write(32'h01020304, 2'd2, "R13 before toggle");
        set_cfg(2'd2, 0, 0, 0, 0, 0, 0);
        do_write(32'h05060708, 2'd2, "R13 after toggle");
        set_cfg(2'd2, 0, 0, 0, 0, 1, 0);
        do_write(32'h0000090A, 2'd1, "R13 second toggle");

        // R14: write behind a busy word is held for 3 cycles
        set_cfg(2'd2, 0, 0, 0, 0, 0, 0);
        do_write(32'h11223344, 2'd2, "R14 first word");
        do_write(32'h55667788, 2'd2, "R14 stalled word");
        chk("R14 stall cycles", last_stall, 3);

        // R6: half-word busy for exactly one cycle
        drain();
        wr_data = 32'h0000ABCD; wr_size = 2'd1; wr_valid = 1;
        @(posedge clk); m_feed(32'h0000ABCD, 2'd1);
        #1 wr_valid = 0;
        @(negedge clk); chk("R6 half busy", {31'h0, busy}, 1);
        chk("R6 ready low while busy", {31'h0, wr_ready}, 0);
        @(negedge clk); chk("R6 half done", {31'h0, busy}, 0);
        chk("R6 half result", checksum, m_out());

        // R6: byte never raises busy
        wr_data = 32'h0000005A; wr_size = 2'd0; wr_valid = 1;
        @(posedge clk); m_feed(32'h0000005A, 2'd0);
        #1 wr_valid = 0;
        @(negedge clk); chk("R6 byte no busy", {31'h0, busy}, 0);
        chk("R6 byte result", checksum, m_out());

        // R3: seed cancels a word in flight; ready low during seed strobe
        wr_data = 32'hFFEEDDCC; wr_size = 2'd2; wr_valid = 1;
        @(posedge clk);
        #1 wr_valid = 0;
        @(negedge clk);
        seed_val = 32'h600D_5EED; seed_wr = 1;
        chk("R3 busy before seed", {31'h0, busy}, 1);
        @(posedge clk);
        #1 wr_valid = 1; wr_data = 32'h0; wr_size = 2'd0;
        chk("R3 ready low with seed", {31'h0, wr_ready}, 0);
        @(negedge clk);
        seed_wr = 0; wr_valid = 0;
        chk("R3 busy cleared", {31'h0, busy}, 0);
        chk("R3 seed loaded", checksum, 32'h600D_5EED);
        @(negedge clk);
        chk("R3 seed held", checksum, 32'h600D_5EED);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule